// File: doc/BRIEF.md
# Dual-Thread Retirement Fingerprint Checker

This block detects faults in redundant execution by watching the retirement streams of two threads that run the same program. Every architectural update a thread retires, whether a register result or a store, is folded into that thread's running 16-bit CRC, its fingerprint. The checker does not compare full machine state or off-chip traffic. It compares one short fingerprint per checkpoint interval. Detection latency is therefore bounded by the interval length, and the comparison costs only a few bits per interval.

Each thread's fingerprint closes after a programmable number of retired updates and then restarts. The closed value waits in a four-entry slip queue for its partner. The two threads may drift apart by up to four checkpoints before the leading thread is stalled.

In pair mode, the checker compares the matching checkpoints of the two threads. A soft error and a divergent load value both show up as differing retired values and raise the same sticky error flag. In reference mode, the checker compares thread 0's fingerprints against a preloaded value and drops thread 1's checkpoints unseen.

Each retirement input is a valid/ready stream. An update transfers on a cycle where valid and ready are both high. While ready is low, the offered update is not taken, and the producer must hold it until ready returns. Ready depends only on the state of that thread's slip queue and never on valid.

Top module: `fp_lockstep_checker`

## Requirements
- R1: After reset, `err_flag` and `ckpt_done` are 0, both `fp*_last` outputs are 0x0000, and both ready outputs are 1.
- R2: An accepted update folds 64 message bits into the thread's CRC in a single cycle, most significant bit first. The first 32 bits are the destination word and the last 32 bits are the data word. The CRC uses polynomial 0x1021, no reflection and no final XOR.
- R3: With `cfg_mode`=0 (pair mode), the k-th checkpoint of thread 0 is compared with the k-th checkpoint of thread 1. Both values are shown on `fp0_last`/`fp1_last` one cycle after both are queued, and any difference sets `err_flag`.
- R4: A fingerprint covers exactly `cfg_interval` accepted updates of its thread (a value of 0 counts as 1). The CRC then restarts from 0xFFFF.
- R5: With `cfg_mode`=1 (reference mode), each thread 0 checkpoint is compared against `cfg_ref`. Thread 1 checkpoints are discarded, so they neither set `err_flag`, nor raise `ckpt_done`, nor change `fp1_last`.
- R6: Each thread queues up to 4 closed checkpoints awaiting comparison. While its queue holds 4, that thread's ready output is 0, no update is accepted and no checkpoint is lost.
- R7: `err_flag` is sticky until `err_clear` is sampled high. If a mismatch is found on the same cycle as a clear, the flag is set.
- R8: `ckpt_done` is high for exactly one cycle per comparison, whether or not the comparison matched.
- R9: The `t*_kind` input selects the update type: 0 is a register write and 1 is a store. For a register write, only `t*_dest[4:0]` is hashed, zero-extended to 32 bits. For a store, the full 32-bit address is hashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 0 = compare the two threads, 1 = compare thread 0 against `cfg_ref` |
| cfg_interval | input | 16 | Updates per checkpoint interval (0 treated as 1) |
| cfg_ref | input | 16 | Reference fingerprint for reference mode |
| err_clear | input | 1 | Clears the sticky error flag |
| t0_valid | input | 1 | Thread 0 update offered |
| t0_ready | output | 1 | Thread 0 update can be taken |
| t0_kind | input | 1 | Thread 0 update type (0 register, 1 store) |
| t0_dest | input | 32 | Thread 0 register index or store address |
| t0_data | input | 32 | Thread 0 result or store data |
| t1_valid | input | 1 | Thread 1 update offered |
| t1_ready | output | 1 | Thread 1 update can be taken |
| t1_kind | input | 1 | Thread 1 update type (0 register, 1 store) |
| t1_dest | input | 32 | Thread 1 register index or store address |
| t1_data | input | 32 | Thread 1 result or store data |
| err_flag | output | 1 | Sticky mismatch indication |
| ckpt_done | output | 1 | One-cycle pulse per comparison |
| fp0_last | output | 16 | Thread 0 fingerprint of the latest comparison |
| fp1_last | output | 16 | Thread 1 fingerprint of the latest pair comparison |

## Verification
The bench lets thread 1 fall behind until thread 0's queue fills. A queue that overwrote its oldest entry, or accepted a fifth checkpoint, would pair fingerprints out of order and raise false mismatches.

It sends register writes that differ only in the unhashed upper destination bits, and stores whose addresses differ. A design that hashed the wrong destination bits would flag the first case or miss the second.

In reference mode, thread 1 carries garbage. Any leak of thread 1 into the compare path would set the error flag or move `fp1_last`.

Holding `err_clear` high while mismatches arrive shows whether a clear wrongly beats a new mismatch on the same cycle.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int FP_W = 16;
  localparam logic [FP_W-1:0] FP_POLY = 16'h1021;
  localparam logic [FP_W-1:0] FP_SEED = 16'hFFFF;

  typedef enum logic {
    UPD_REG   = 1'b0,
    UPD_STORE = 1'b1
  } upd_kind_e;

  typedef enum logic {
    CMP_PAIR = 1'b0,
    CMP_REF  = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/fp_crc_lane.sv
module fp_crc_lane
  import fp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic              in_kind,
  input  logic [WORD_W-1:0] in_dest,
  input  logic [WORD_W-1:0] in_data,
  input  logic [CNT_W-1:0]  interval,
  output logic              close_vld,
  output logic [FP_W-1:0]   close_fp
);
  localparam int MSG_W = 2 * WORD_W;

  logic [FP_W-1:0]  crc_q, crc_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc, limit;
  logic [WORD_W-1:0] dest_word;
  logic [MSG_W-1:0]  msg;
  logic              fb;

  always_comb begin
    if (upd_kind_e'(in_kind) == UPD_STORE) dest_word = in_dest;
    else dest_word = {{(WORD_W-IDX_W){1'b0}}, in_dest[IDX_W-1:0]};
    msg   = {dest_word, in_data};
    crc_n = crc_q;
    for (int b = MSG_W - 1; b >= 0; b--) begin
      fb    = crc_n[FP_W-1] ^ msg[b];
      crc_n = {crc_n[FP_W-2:0], 1'b0} ^ (fb ? FP_POLY : '0);
    end
  end

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    limit   = (interval == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, interval};
  end

  assign close_vld = in_fire && (cnt_inc >= limit);
  assign close_fp  = crc_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= FP_SEED;
      cnt_q <= '0;
    end else if (in_fire) begin
      if (close_vld) begin
        crc_q <= FP_SEED;
        cnt_q <= '0;
      end else begin
        crc_q <= crc_n;
        cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  end

  // R4
  crc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_vld |=> (crc_q == FP_SEED) && (cnt_q == '0));
endmodule

// File: rtl/fp_slip_fifo.sv
module fp_slip_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [OCC_W-1:0] occ_q;

  assign empty = (occ_q == '0);
  assign full  = (occ_q == FULL_OCC);
  assign head  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push && !pop)      occ_q <= occ_q + 1'b1;
      else if (pop && !push) occ_q <= occ_q - 1'b1;
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/fp_compare.sv
module fp_compare
  import fp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode,
  input  logic [FP_W-1:0] ref_fp,
  input  logic            err_clear,
  input  logic            q0_empty,
  input  logic            q1_empty,
  input  logic [FP_W-1:0] head0,
  input  logic [FP_W-1:0] head1,
  output logic            pop0,
  output logic            pop1,
  output logic            done,
  output logic            err,
  output logic [FP_W-1:0] last0,
  output logic [FP_W-1:0] last1
);
  logic fire, mism, pair;

  always_comb begin
    pair = (cmp_mode_e'(mode) == CMP_PAIR);
    if (pair) begin
      fire = !q0_empty && !q1_empty;
      pop0 = fire;
      pop1 = fire;
      mism = (head0 != head1);
    end else begin
      fire = !q0_empty;
      pop0 = fire;
      pop1 = !q1_empty;
      mism = (head0 != ref_fp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      err   <= 1'b0;
      last0 <= '0;
      last1 <= '0;
    end else begin
      done <= fire;
      if (fire) last0 <= head0;
      if (fire && pair) last1 <= head1;
      if (fire && mism) err <= 1'b1;
      else if (err_clear) err <= 1'b0;
    end
  end

  // R7
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !err_clear |=> err);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mism |=> err && done);
endmodule

// File: rtl/fp_lockstep_checker.sv
module fp_lockstep_checker
  import fp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 5,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic [CNT_W-1:0]  cfg_interval,
  input  logic [FP_W-1:0]   cfg_ref,
  input  logic              err_clear,
  input  logic              t0_valid,
  output logic              t0_ready,
  input  logic              t0_kind,
  input  logic [WORD_W-1:0] t0_dest,
  input  logic [WORD_W-1:0] t0_data,
  input  logic              t1_valid,
  output logic              t1_ready,
  input  logic              t1_kind,
  input  logic [WORD_W-1:0] t1_dest,
  input  logic [WORD_W-1:0] t1_data,
  output logic              err_flag,
  output logic              ckpt_done,
  output logic [FP_W-1:0]   fp0_last,
  output logic [FP_W-1:0]   fp1_last
);
  localparam int NT = 2;

  logic              vld  [NT];
  logic              kind [NT];
  logic [WORD_W-1:0] dest [NT];
  logic [WORD_W-1:0] data [NT];
  logic              fire [NT];
  logic              cl_v [NT];
  logic [FP_W-1:0]   cl_fp[NT];
  logic              pop  [NT];
  logic              emp  [NT];
  logic              ful  [NT];
  logic [FP_W-1:0]   hd   [NT];

  always_comb begin
    vld[0] = t0_valid; kind[0] = t0_kind; dest[0] = t0_dest; data[0] = t0_data;
    vld[1] = t1_valid; kind[1] = t1_kind; dest[1] = t1_dest; data[1] = t1_data;
  end

  assign t0_ready = !ful[0];
  assign t1_ready = !ful[1];

  for (genvar i = 0; i < NT; i++) begin : g_thr
    assign fire[i] = vld[i] && !ful[i];

    fp_crc_lane #(.WORD_W(WORD_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_fire  (fire[i]),
      .in_kind  (kind[i]),
      .in_dest  (dest[i]),
      .in_data  (data[i]),
      .interval (cfg_interval),
      .close_vld(cl_v[i]),
      .close_fp (cl_fp[i])
    );

    fp_slip_fifo #(.W(FP_W), .DEPTH(QDEPTH)) u_slip (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (cl_v[i]),
      .push_data(cl_fp[i]),
      .pop      (pop[i]),
      .head     (hd[i]),
      .empty    (emp[i]),
      .full     (ful[i])
    );
  end

  fp_compare u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg_mode),
    .ref_fp   (cfg_ref),
    .err_clear(err_clear),
    .q0_empty (emp[0]),
    .q1_empty (emp[1]),
    .head0    (hd[0]),
    .head1    (hd[1]),
    .pop0     (pop[0]),
    .pop1     (pop[1]),
    .done     (ckpt_done),
    .err      (err_flag),
    .last0    (fp0_last),
    .last1    (fp1_last)
  );

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_done && !$past(pop[0]) |-> 1'b0);
endmodule

// File: tb/tb_fp_lockstep_checker.sv
module tb_fp_lockstep_checker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cfg_mode, err_clear;
  logic [15:0] cfg_interval, cfg_ref;
  logic        t0_valid, t0_kind, t1_valid, t1_kind;
  logic        t0_ready, t1_ready;
  logic [31:0] t0_dest, t0_data, t1_dest, t1_data;
  logic        err_flag, ckpt_done;
  logic [15:0] fp0_last, fp1_last;

  fp_lockstep_checker dut (.*);

  typedef struct packed { logic kind; logic [31:0] dest; logic [31:0] data; } upd_t;

  upd_t        pend0[$], pend1[$];
  logic [15:0] exq0[$], exq1[$];
  logic [15:0] mcrc[2];
  int          mcnt[2];
  int          go0, go1, acc0;
  int          checks = 0, fails = 0, cycles = 0;
  logic        err_m = 1'b0, clr_hold = 1'b0;

  function automatic logic [15:0] fold(logic [15:0] c, upd_t u);
    logic [63:0] m;
    logic fb;
    m = {(u.kind ? u.dest : {27'd0, u.dest[4:0]}), u.data};
    for (int b = 63; b >= 0; b--) begin
      fb = c[15] ^ m[b];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic upd_t rnd_upd();
    upd_t u;
    u.kind = 1'($urandom % 2);
    u.dest = $urandom;
    u.data = $urandom;
    return u;
  endfunction

  task automatic model_accept(input int t, input upd_t u);
    int lim;
    lim = (cfg_interval == 0) ? 1 : int'(cfg_interval);
    mcrc[t] = fold(mcrc[t], u);
    mcnt[t]++;
    if (mcnt[t] >= lim) begin
      if (t == 0) exq0.push_back(mcrc[t]);
      else if (cfg_mode == 1'b0) exq1.push_back(mcrc[t]);
      mcrc[t] = 16'hFFFF;
      mcnt[t] = 0;
    end
  endtask

  task automatic step();
    @(negedge clk);
    t0_valid = 1'b0; t1_valid = 1'b0;
    if (pend0.size() > 0 && ($urandom % 100) < go0) begin
      t0_valid = 1'b1; t0_kind = pend0[0].kind; t0_dest = pend0[0].dest; t0_data = pend0[0].data;
    end
    if (pend1.size() > 0 && ($urandom % 100) < go1) begin
      t1_valid = 1'b1; t1_kind = pend1[0].kind; t1_dest = pend1[0].dest; t1_data = pend1[0].data;
    end
    if (t0_valid && t0_ready) begin model_accept(0, pend0.pop_front()); acc0++; end
    if (t1_valid && t1_ready) model_accept(1, pend1.pop_front());
  endtask

  task automatic drain(input string req);
    while (pend0.size() > 0 || pend1.size() > 0) step();
    repeat (8) step();
    chk(exq0.size() == 0 && exq1.size() == 0, req, exq0.size(), 0);
  endtask

  task automatic gen_pair(input int n, input int err_pct);
    for (int k = 0; k < n; k++) begin
      upd_t u, v;
      u = rnd_upd();
      v = u;
      if (($urandom % 100) < err_pct) v.data = v.data ^ (32'd1 << ($urandom % 32));
      pend0.push_back(u);
      pend1.push_back(v);
    end
  endtask

  // completion checker: R3, R5, R8, R7
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (ckpt_done) begin
        logic [15:0] e0, e1;
        logic mism;
        e0 = exq0.pop_front();
        chk(fp0_last == e0, "R3 fp0_last", fp0_last, e0);
        if (cfg_mode == 1'b0) begin
          e1 = exq1.pop_front();
          chk(fp1_last == e1, "R3 fp1_last", fp1_last, e1);
          mism = (e0 != e1);
        end else begin
          mism = (e0 != cfg_ref);
        end
        err_m = mism ? 1'b1 : (clr_hold ? 1'b0 : err_m);
        chk(err_flag == err_m, "R7 err_flag at compare", err_flag, err_m);
      end
    end
  end

  initial begin
    int done_cnt;
    upd_t u, v;
    logic [15:0] f1_hold, rv;
    upd_t chunk[$];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_mode = 1'b0; err_clear = 1'b0; cfg_interval = 16'd1; cfg_ref = 16'h0;
    t0_valid = 0; t1_valid = 0; t0_kind = 0; t1_kind = 0;
    t0_dest = 0; t1_dest = 0; t0_data = 0; t1_data = 0;
    mcrc[0] = 16'hFFFF; mcrc[1] = 16'hFFFF; mcnt[0] = 0; mcnt[1] = 0;
    go0 = 100; go1 = 100; acc0 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(err_flag == 0 && ckpt_done == 0, "R1 flags", {err_flag, ckpt_done}, 0);
    chk(fp0_last == 0 && fp1_last == 0, "R1 last", {fp0_last, fp1_last}, 0);
    chk(t0_ready && t1_ready, "R1 ready", {t0_ready, t1_ready}, 2'b11);

    // R2: single update per interval, known fold
    u = '{kind: 1'b1, dest: 32'h1000_0040, data: 32'hDEAD_BEEF};
    pend0.push_back(u); pend1.push_back(u);
    drain("R2 one store");
    chk(fp0_last == fold(16'hFFFF, u), "R2 crc value", fp0_last, fold(16'hFFFF, u));
    chk(err_flag == 0, "R2 no error", err_flag, 0);

    // R9: register index upper bits ignored, store address fully hashed
    u = '{kind: 1'b0, dest: 32'h0000_0003, data: 32'h1234_5678};
    v = '{kind: 1'b0, dest: 32'hFFFF_FFE3, data: 32'h1234_5678};
    pend0.push_back(u); pend1.push_back(v);
    drain("R9 reg drain");
    chk(err_flag == 0 && fp0_last == fp1_last, "R9 reg index masked", fp1_last, fp0_last);
    u.kind = 1'b1; v.kind = 1'b1;
    pend0.push_back(u); pend1.push_back(v);
    drain("R9 store drain");
    chk(err_flag == 1, "R9 store address hashed", err_flag, 1);
    @(negedge clk); err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; err_m = 1'b0;
    chk(err_flag == 0, "R7 clear", err_flag, 0);

    // R4: interval 0 acts as 1, then interval 5 with random clean traffic
    cfg_interval = 16'd0;
    gen_pair(3, 0);
    drain("R4 interval zero");
    cfg_interval = 16'd5;
    go0 = 70; go1 = 40;
    gen_pair(5 * 20, 0);
    drain("R4 interval five");
    chk(err_flag == 0, "R4 clean run", err_flag, 0);

    // R6: thread 1 stalled, thread 0 queue fills
    cfg_interval = 16'd1;
    go0 = 100; go1 = 0; acc0 = 0;
    gen_pair(6, 0);
    repeat (12) step();
    chk(acc0 == 4, "R6 accepted before stall", acc0, 4);
    chk(t0_ready == 0, "R6 ready low when full", t0_ready, 0);
    go1 = 100;
    drain("R6 release");
    chk(acc0 == 6, "R6 no loss", acc0, 6);

    // R3: random traffic with injected divergences
    cfg_interval = 16'd3;
    go0 = 60; go1 = 60;
    gen_pair(3 * 40, 4);
    drain("R3 random mismatch");
    @(negedge clk); err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; err_m = 1'b0;

    // R7: clear held while mismatches arrive; set must win
    clr_hold = 1'b1; err_clear = 1'b1;
    cfg_interval = 16'd2;
    gen_pair(2 * 20, 25);
    drain("R7 held clear");
    clr_hold = 1'b0; err_clear = 1'b0; err_m = 1'b0;
    @(negedge clk);
    chk(err_flag == 0, "R7 flag cleared", err_flag, 0);

    // R5: reference mode, thread 1 garbage
    cfg_mode = 1'b1; cfg_interval = 16'd4;
    rv = 16'hFFFF;
    for (int k = 0; k < 4; k++) begin chunk.push_back(rnd_upd()); rv = fold(rv, chunk[k]); end
    cfg_ref = rv;
    f1_hold = fp1_last;
    for (int r = 0; r < 6; r++) for (int k = 0; k < 4; k++) pend0.push_back(chunk[k]);
    for (int k = 0; k < 24; k++) pend1.push_back(rnd_upd());
    go0 = 80; go1 = 90;
    drain("R5 ref drain");
    chk(err_flag == 0, "R5 thread1 ignored", err_flag, 0);
    chk(fp1_last == f1_hold, "R5 fp1_last unchanged", fp1_last, f1_hold);
    u = chunk[2]; u.data = ~u.data;
    pend0.push_back(chunk[0]); pend0.push_back(chunk[1]); pend0.push_back(u); pend0.push_back(chunk[3]);
    drain("R5 bad chunk");
    chk(err_flag == 1, "R5 reference mismatch", err_flag, 1);

    // R8: exactly one pulse per comparison
    cfg_mode = 1'b0; cfg_interval = 16'd1;
    @(negedge clk); err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; err_m = 1'b0;
    gen_pair(5, 0);
    done_cnt = 0;
    while (pend0.size() > 0 || pend1.size() > 0) begin step(); if (ckpt_done) done_cnt++; end
    repeat (8) begin step(); if (ckpt_done) done_cnt++; end
    chk(done_cnt == 5, "R8 pulse count", done_cnt, 5);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule